// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block sits beside the decode stage of a five-stage in-order pipeline that evaluates branch-if-equal in decode, using an equality comparator on the two source operands and an adder for the target. Each cycle it compares the branch's two source register numbers against the destinations of the instructions in the execute, memory and write-back stages. From those matches it either picks a forwarding source for each comparator input or requests a stall.

Whether the branch stalls depends on how far back the producer is and what kind of instruction it is. An ALU result two or three instructions back is forwarded with no stall. An ALU result one instruction back, or a load two instructions back, costs one stall cycle. A load one instruction back costs two stall cycles. When a stall is requested, the surrounding pipeline holds the PC and the fetch/decode register and sends a bubble into execute. The stall length is not counted anywhere in the block: the bubble moves the producer one stage further each cycle, and the request clears once the value can be forwarded. Fetch keeps predicting not taken. The block resolves the branch with the forwarded operands and raises a flush when the branch is taken, so the wrongly fetched instruction is squashed and the PC is loaded with the target output.

The block is purely combinational and has no clock and no reset.

Top module: `br_hazard`

## Requirements
- R1: When `is_branch` is low, `stall` and `flush` are low and both forwarding selects are 2'b00, whatever the stage inputs are.
- R2: A branch whose source matches the destination of a writing instruction in execute (`ex_wen` high, nonzero `ex_dst`) raises `stall`, whether that producer is an ALU operation or a load. An ALU producer immediately before the branch therefore costs exactly one stall cycle.
- R3: A branch whose source matches the destination of a load in the memory stage (`mem_wen` and `mem_load` high, nonzero `mem_dst`) raises `stall`. A load immediately before the branch costs exactly two stall cycles, and a load two instructions back costs exactly one.
- R4: A source that matches a non-load writer in the memory stage is forwarded from `mem_res`, with select code 2'b10, and causes no stall.
- R5: A source that matches a writer in write-back is forwarded from `wb_res`, with select code 2'b01, and causes no stall.
- R6: When both the memory stage and write-back match the same source, the memory stage wins because it holds the younger value.
- R7: Register 0, and any stage whose write enable is low, never cause a stall or a forward. Such a source uses select 2'b00, which is the register-file value.
- R8: `flush` is high exactly when a branch is present, `stall` is low, and the two selected comparator operands are equal.
- R9: `target` equals `pc_seq` plus four times the signed word offset `br_off`, modulo 2^XLEN.
- R10: While `stall` is high, `flush` is low and both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_branch | input | 1 | A branch-if-equal is in decode |
| src_a | input | RW | First comparison register number |
| src_b | input | RW | Second comparison register number |
| rf_a | input | XLEN | Register-file value of src_a |
| rf_b | input | XLEN | Register-file value of src_b |
| pc_seq | input | XLEN | Address of the instruction after the branch |
| br_off | input | XLEN | Sign-extended word offset of the branch |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | RW | Execute-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | RW | Memory-stage destination register |
| mem_res | input | XLEN | Memory-stage ALU result |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_dst | input | RW | Write-back destination register |
| wb_res | input | XLEN | Write-back result |
| stall | output | 1 | Hold PC and fetch/decode, send a bubble into execute |
| fwd_a | output | 2 | Source select for operand A: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Source select for operand B, same encoding |
| flush | output | 1 | Branch taken: squash the fetched instruction |
| target | output | XLEN | Branch target address |

## Verification
The block holds no state, so a wrong decision shows at the ports in the same cycle as the input pattern that triggers it. A matching condition that is missed shows up as a select of 00 or a missing `stall`. A wrong priority between stages shows up as the wrong select code, or as a `flush` that follows a stale operand. The stall lengths of R2 and R3 only appear over several cycles. The bench therefore runs short producer-then-branch sequences through a behavioural pipeline history, where each stall pushes a bubble. A stall that ends one cycle too early or too late changes the stall count it observes.

// File: rtl/br_hazard.sv
module br_hazard #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            is_branch,
  input  logic [RW-1:0]   src_a,
  input  logic [RW-1:0]   src_b,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] pc_seq,
  input  logic [XLEN-1:0] br_off,
  input  logic            ex_wen,
  input  logic [RW-1:0]   ex_dst,
  input  logic            mem_wen,
  input  logic            mem_load,
  input  logic [RW-1:0]   mem_dst,
  input  logic [XLEN-1:0] mem_res,
  input  logic            wb_wen,
  input  logic [RW-1:0]   wb_dst,
  input  logic [XLEN-1:0] wb_res,
  output logic            stall,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            flush,
  output logic [XLEN-1:0] target
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic [RW-1:0]   src [2];
  logic [XLEN-1:0] rfv [2];
  logic [XLEN-1:0] opv [2];
  logic [1:0]      sel [2];
  logic [1:0]      need;

  assign src[0] = src_a;
  assign src[1] = src_b;
  assign rfv[0] = rf_a;
  assign rfv[1] = rf_b;

  wire ex_live  = ex_wen  && (ex_dst  != '0);
  wire mem_live = mem_wen && (mem_dst != '0);
  wire wb_live  = wb_wen  && (wb_dst  != '0);

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    wire hit_ex  = ex_live  && (ex_dst  == src[i]);
    wire hit_mem = mem_live && (mem_dst == src[i]);
    wire hit_wb  = wb_live  && (wb_dst  == src[i]);

    assign need[i] = hit_ex || (hit_mem && mem_load);

    always_comb begin
      if (!is_branch || stall) sel[i] = SEL_RF;
      else if (hit_mem)        sel[i] = SEL_MEM;
      else if (hit_wb)         sel[i] = SEL_WB;
      else                     sel[i] = SEL_RF;
    end

    assign opv[i] = (sel[i] == SEL_MEM) ? mem_res :
                    (sel[i] == SEL_WB)  ? wb_res  : rfv[i];
  end

  assign stall  = is_branch && (|need);
  assign fwd_a  = sel[0];
  assign fwd_b  = sel[1];
  assign flush  = is_branch && !stall && (opv[0] == opv[1]);
  assign target = pc_seq + (br_off << 2);

endmodule

module br_hazard_chk #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input logic          is_branch,
  input logic [RW-1:0] src_a,
  input logic [RW-1:0] src_b,
  input logic          ex_wen,
  input logic [RW-1:0] ex_dst,
  input logic          mem_wen,
  input logic          mem_load,
  input logic [RW-1:0] mem_dst,
  input logic          stall,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          flush
);
  always_comb begin
    if (!$isunknown({is_branch, src_a, src_b, ex_wen, ex_dst, mem_wen, mem_load,
                     mem_dst, stall, fwd_a, fwd_b, flush})) begin
      if (!is_branch)
        p_idle_quiet_r1: assert (!stall && !flush && fwd_a == 2'b00 && fwd_b == 2'b00);
      if (is_branch && ex_wen && ex_dst != '0 && (ex_dst == src_a || ex_dst == src_b))
        p_ex_producer_stalls_r2: assert (stall);
      if (is_branch && mem_wen && mem_load && mem_dst != '0 &&
          (mem_dst == src_a || mem_dst == src_b))
        p_mem_load_stalls_r3: assert (stall);
      if (fwd_a == 2'b10)
        p_mem_fwd_source_r4: assert (mem_wen && !mem_load && mem_dst == src_a && src_a != '0);
      if (src_a == '0)
        p_zero_reg_rf_r7: assert (fwd_a == 2'b00);
      if (flush)
        p_flush_needs_branch_r8: assert (is_branch);
      if (stall)
        p_stall_quiet_r10: assert (!flush && fwd_a == 2'b00 && fwd_b == 2'b00);
    end
  end
endmodule

bind br_hazard br_hazard_chk #(.XLEN(XLEN), .RW(RW)) u_chk (
  .is_branch(is_branch), .src_a(src_a), .src_b(src_b),
  .ex_wen(ex_wen), .ex_dst(ex_dst),
  .mem_wen(mem_wen), .mem_load(mem_load), .mem_dst(mem_dst),
  .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b), .flush(flush)
);

// File: tb/br_hazard_bench.sv
module br_hazard_bench;
  localparam int XLEN = 32;
  localparam int RW   = 5;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic            is_branch;
  logic [RW-1:0]   src_a, src_b;
  logic [XLEN-1:0] rf_a, rf_b, pc_seq, br_off, mem_res, wb_res;
  logic            stall, flush;
  logic [1:0]      fwd_a, fwd_b;
  logic [XLEN-1:0] target;

  int  h_dst  [3];
  bit  h_wen  [3];
  bit  h_load [3];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  br_hazard #(.XLEN(XLEN), .RW(RW)) u_br_hazard (
    .is_branch(is_branch), .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
    .pc_seq(pc_seq), .br_off(br_off),
    .ex_wen(h_wen[0]), .ex_dst(RW'(h_dst[0])),
    .mem_wen(h_wen[1]), .mem_load(h_load[1]), .mem_dst(RW'(h_dst[1])), .mem_res(mem_res),
    .wb_wen(h_wen[2]), .wb_dst(RW'(h_dst[2])), .wb_res(wb_res),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b), .flush(flush), .target(target)
  );

  task automatic ref_op(input int s, output bit st, output int fw);
    st = 0; fw = 0;
    for (int d = 0; d < 3; d++) begin
      if (h_wen[d] && h_dst[d] != 0 && h_dst[d] == s) begin
        if (d == 0) st = 1;
        else if (d == 1) begin if (h_load[1]) st = 1; else fw = 2; end
        else fw = 1;
        return;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit sa, sb, es, ef;
    int fa, fb;
    logic [XLEN-1:0] va, vb;
    ref_op(src_a, sa, fa);
    ref_op(src_b, sb, fb);
    es = is_branch && (sa || sb);
    if (!is_branch || es) begin fa = 0; fb = 0; end
    va = fa == 2 ? mem_res : fa == 1 ? wb_res : rf_a;
    vb = fb == 2 ? mem_res : fb == 1 ? wb_res : rf_b;
    ef = is_branch && !es && (va == vb);
    chk(stall === es, tag, "stall", stall, es);
    chk(fwd_a === 2'(fa), tag, "fwd_a", fwd_a, fa);
    chk(fwd_b === 2'(fb), tag, "fwd_b", fwd_b, fb);
    chk(flush === ef, tag, "flush", flush, ef);
    chk(target === pc_seq + br_off * 4, tag, "target", target, pc_seq + br_off * 4);
  endtask

  task automatic clear_hist();
    for (int d = 0; d < 3; d++) begin h_dst[d] = 0; h_wen[d] = 0; h_load[d] = 0; end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    compare(tag);
    @(posedge clk); #2;
  endtask

  task automatic run_seq(input bit ld, input int gap, input int exp_stalls, input string tag);
    int cnt = 0;
    clear_hist();
    h_dst[gap] = 3; h_wen[gap] = 1; h_load[gap] = ld;
    is_branch = 1; src_a = 3; src_b = 0; rf_a = 0; rf_b = 0;
    mem_res = 'h11; wb_res = 'h22;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      compare(tag);
      if (!stall) break;
      cnt++;
      @(posedge clk); #2;
      for (int d = 2; d > 0; d--) begin
        h_dst[d] = h_dst[d-1]; h_wen[d] = h_wen[d-1]; h_load[d] = h_load[d-1];
      end
      h_dst[0] = 0; h_wen[0] = 0; h_load[0] = 0;
    end
    chk(cnt == exp_stalls, tag, "stall cycles", cnt, exp_stalls);
    @(posedge clk); #2;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    clear_hist();
    is_branch = 0; src_a = 0; src_b = 0; rf_a = 0; rf_b = 0;
    pc_seq = 'h100; br_off = 0; mem_res = 0; wb_res = 0;
    repeat (3) @(posedge clk);
    rst_n = 1; #2;
    step("R1 quiescent");

    // R1: hazards present but no branch
    h_dst[0] = 4; h_wen[0] = 1; h_dst[1] = 5; h_wen[1] = 1; h_load[1] = 1;
    src_a = 4; src_b = 5; step("R1 no branch");

    // R2: ALU in execute
    clear_hist(); is_branch = 1; h_dst[0] = 7; h_wen[0] = 1; src_a = 1; src_b = 7;
    rf_a = 9; rf_b = 9; step("R2 ex alu");
    // R3: load in memory stage
    clear_hist(); h_dst[1] = 6; h_wen[1] = 1; h_load[1] = 1; src_a = 6; src_b = 2;
    step("R3 mem load");
    // R4: ALU in memory forwarded, equal and unequal
    clear_hist(); h_dst[1] = 8; h_wen[1] = 1; src_a = 8; src_b = 2;
    mem_res = 'h55; rf_a = 'h99; rf_b = 'h55; step("R4 mem fwd taken");
    rf_b = 'h99; step("R4 mem fwd not taken R8");
    // R5: write-back forwarding
    clear_hist(); h_dst[2] = 9; h_wen[2] = 1; src_a = 2; src_b = 9;
    wb_res = 'h3; rf_a = 'h3; rf_b = 'h7; step("R5 wb fwd");
    // R6: memory beats write-back
    clear_hist(); h_dst[1] = 10; h_wen[1] = 1; h_dst[2] = 10; h_wen[2] = 1;
    src_a = 10; src_b = 10; mem_res = 'hA; wb_res = 'hB; step("R6 priority");
    // R7: register 0 and disabled writers
    clear_hist(); h_dst[0] = 0; h_wen[0] = 1; h_dst[1] = 0; h_wen[1] = 1; h_load[1] = 1;
    src_a = 0; src_b = 0; step("R7 reg zero");
    clear_hist(); h_dst[0] = 12; h_dst[1] = 12; h_load[1] = 1; h_dst[2] = 12;
    src_a = 12; src_b = 12; step("R7 wen low");
    // R10: stall blocks flush even if operands equal
    clear_hist(); h_dst[0] = 13; h_wen[0] = 1; src_a = 13; src_b = 1;
    rf_a = 5; rf_b = 5; step("R10 stall no flush");
    // R9: target
    clear_hist(); src_a = 1; src_b = 2; rf_a = 1; rf_b = 1;
    pc_seq = 'h2000; br_off = -32'sd5; step("R9 negative offset");
    br_off = 'h40; step("R9 positive offset");

    // R2, R3: stall lengths through a moving pipeline
    run_seq(0, 0, 1, "R2 alu then branch");
    run_seq(1, 0, 2, "R3 load then branch");
    run_seq(1, 1, 1, "R3 load two back");
    run_seq(0, 1, 0, "R4 alu two back");
    run_seq(0, 2, 0, "R5 alu three back");

    // R8: random patterns on a small register range
    for (int n = 0; n < 400; n++) begin
      for (int d = 0; d < 3; d++) begin
        h_dst[d] = $urandom_range(0, 3); h_wen[d] = $urandom_range(0, 1);
        h_load[d] = $urandom_range(0, 1);
      end
      is_branch = $urandom_range(0, 3) != 0;
      src_a = RW'($urandom_range(0, 3)); src_b = RW'($urandom_range(0, 3));
      rf_a = $urandom_range(0, 2); rf_b = $urandom_range(0, 2);
      mem_res = $urandom_range(0, 2); wb_res = $urandom_range(0, 2);
      pc_seq = $urandom; br_off = $urandom;
      step("R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule